// File: doc/BRIEF.md
# Rotating Register Window Controller

This block owns a physical register file of `NAREG` words organised as groups of four, and presents software with a sixteen-register logical view that slides over it. A group pointer (the window base) selects where logical register 0 lands. A one-bit-per-group ownership map records which groups hold live frames. The block carries out the operations that move the window: procedure entry, windowed return, relative rotation, restore of a saved base, and the stack-pointer-move check. On each entry or return it decides whether the move is legal, whether a frame must first be spilled (overflow) or refilled (underflow), and which handler size (4, 8 or 12 registers) applies.

One operation is accepted per clock through `op_valid` and `op_code`. Its effects appear at the following clock edge: window state, exception mode and the saved base update, and a one-cycle trap pulse or return pulse is raised. A separate write port and a combinational read port address the file through the current window. Decode, spill and fill traffic and the handlers themselves live outside this block. `busy` is always low because every operation finishes in one cycle.

Top module: `regwin_ctrl`

## Requirements
- R1: After reset the window base is 0, the ownership map holds only bit 0, exception mode is clear, no trap or return pulse is raised, and `busy` is low at all times.
- R2: Logical register r (0..15) reads and writes physical word (4*base + r) mod NAREG, wrapping past the end of the file. The port write (`rf_we`) takes effect only in cycles where `op_valid` is low.
- R3: Entry (op_code 0) is illegal when `op_s` > 3, when `ovf_en` is low, or when exception mode is set. An illegal entry raises trap code 1, sets exception mode, and leaves the base, the map and the file unchanged.
- R4: On a legal entry, let v be the map rotated so that the bit of group base+1 sits in bit 0. If any of the low `op_callinc` bits of v is set, it is an overflow. Let k be the lowest set bit of v. The base advances by k+1, the old base is saved and exception mode is set. The trap code is 3, 4 or 5 (handler of 4, 8 or 12 registers) when the first set bit of v above k lies at k+1, at k+2, or elsewhere or nowhere.
- R5: A legal entry without overflow writes logical register s minus (`op_imm` << 3) into logical register (4*`op_callinc` + s) of the current window. It then adds `op_callinc` to the base (mod NAREG/4) and sets the map bit of the new base.
- R6: Return (op_code 1) reads n from bits [31:30] of logical register 0, and m as 1, 2 or 3 for the first of base-1, base-2, base-3 whose map bit is set (0 if none). It is illegal, with trap code 1 and exception mode set, when n = 0, when m ≠ 0 and m ≠ n, when `ovf_en` is low, or when exception mode is set.
- R7: A legal return that does not underflow pulses `ret_valid`. `ret_pc` is `op_pc_region` in bits [31:30] and bits [29:0] of logical register 0 below them.
- R8: A legal return moves the base back by n. If the new base's map bit is set, the old base's bit is cleared. Otherwise it is an underflow: the map is kept, the old base is saved, exception mode is set, and the trap code is 5+n (6, 7, 8 for handlers of 4, 8, 12 registers).
- R9: Restore (op_code 4) sets the base to the saved base.
- R10: Stack-pointer move (op_code 3) raises trap code 2 and sets exception mode when none of the map bits of base-1, base-2, base-3 is set. Otherwise it changes nothing.
- R11: Rotate (op_code 2) adds the signed 4-bit `op_arg[3:0]` to the base modulo NAREG/4. Op_code 5 loads the base from `op_arg`, op_code 6 loads the map from `op_arg`, and op_code 7 clears exception mode.
- R12: `trap_valid`, `trap_code` and `ret_valid` are valid only in the cycle after the operation's edge. With no operation, the base, the map and exception mode hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ovf_en | input | 1 | Window-overflow detection enable |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 3 | Operation select |
| op_s | input | 4 | Stack-register field of an entry |
| op_imm | input | 12 | Frame size of an entry, in 8-byte units |
| op_callinc | input | 2 | Call increment for an entry |
| op_arg | input | NAREG/4 | Rotate amount, base value or map value |
| op_pc_region | input | 2 | Bits [31:30] of the current program counter |
| rf_we | input | 1 | Logical register write enable |
| rf_waddr | input | 4 | Logical register write address |
| rf_wdata | input | DW | Write data |
| rf_raddr | input | 4 | Logical register read address |
| rf_rdata | output | DW | Read data, combinational |
| win_base | output | log2(NAREG/4) | Current window base |
| win_start | output | NAREG/4 | Frame ownership map |
| exc_mode | output | 1 | Exception mode flag |
| saved_base | output | log2(NAREG/4) | Base saved at the last overflow or underflow |
| trap_valid | output | 1 | Trap pulse |
| trap_code | output | 4 | Trap cause |
| ret_valid | output | 1 | Return pulse |
| ret_pc | output | DW | Return address |
| busy | output | 1 | Always low |

## Verification
The bench sweeps every base against a set of ownership patterns and every call increment and return count. Its main targets are the circular scan that wraps past the top group, the choice between the 8- and 12-register handlers when no later owner exists, and the return check that sees a stale owner at a different distance. A rotation taken from base instead of base+1 would report spurious overflows on a freshly entered frame. A scan without wraparound would miss owners below the base and skip the trap. A return that cleared the old bit on an underflow would lose the frame that the fill handler must restore. Register mapping is checked at every base so that an off-by-one wrap corrupts words visibly.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  typedef enum logic [2:0] {
    WOP_ENTRY    = 3'd0,
    WOP_RETURN   = 3'd1,
    WOP_ROTATE   = 3'd2,
    WOP_SPMOVE   = 3'd3,
    WOP_RESTORE  = 3'd4,
    WOP_SETBASE  = 3'd5,
    WOP_SETMAP   = 3'd6,
    WOP_CLREXC   = 3'd7
  } win_op_e;

  localparam logic [3:0] TC_NONE    = 4'd0;
  localparam logic [3:0] TC_ILLEGAL = 4'd1;
  localparam logic [3:0] TC_ALLOCA  = 4'd2;
  localparam logic [3:0] TC_OVF4    = 4'd3;
  localparam logic [3:0] TC_OVF8    = 4'd4;
  localparam logic [3:0] TC_OVF12   = 4'd5;
  localparam logic [3:0] TC_UNF4    = 4'd6;
  localparam logic [3:0] TC_UNF8    = 4'd7;
  localparam logic [3:0] TC_UNF12   = 4'd8;

endpackage

// File: rtl/regwin_scan.sv
// Overflow scan: circular view of the ownership map starting just above
// the base, first-owner search and handler size selection.
module regwin_scan
  import regwin_pkg::*;
#(
  parameter int NGRP = 8,
  parameter int GW   = 3
) (
  input  logic [NGRP-1:0] start_i,
  input  logic [GW-1:0]   base_i,
  input  logic [1:0]      callinc_i,
  output logic            ovf_o,
  output logic [GW-1:0]   adv_o,
  output logic [3:0]      code_o
);

  logic [NGRP-1:0] rot;
  logic [2:0]      cmask;
  logic [1:0]      first;
  logic [GW-1:0]   step;

  // bit g of the rotated view is the group g+1 places above the base
  for (genvar g = 0; g < NGRP; g++) begin : g_rot
    assign rot[g] = start_i[base_i + GW'(g + 1)];
  end

  always_comb begin
    cmask = 3'b000;
    for (int i = 0; i < 3; i++) begin
      if (i < int'(callinc_i)) cmask[i] = 1'b1;
    end
    ovf_o = |(rot[2:0] & cmask);

    if (rot[0])      first = 2'd0;
    else if (rot[1]) first = 2'd1;
    else             first = 2'd2;

    step  = GW'(first) + GW'(1);
    adv_o = step;

    if (rot[step])                code_o = TC_OVF4;
    else if (rot[step + GW'(1)])  code_o = TC_OVF8;
    else                          code_o = TC_OVF12;
  end

endmodule

// File: rtl/regwin_lookback.sv
// Looks at the three groups below the base for the nearest live frame.
module regwin_lookback #(
  parameter int NGRP = 8,
  parameter int GW   = 3
) (
  input  logic [NGRP-1:0] start_i,
  input  logic [GW-1:0]   base_i,
  output logic [1:0]      dist_o,
  output logic            none_o
);

  logic [GW-1:0] g1, g2, g3;

  assign g1 = base_i - GW'(1);
  assign g2 = base_i - GW'(2);
  assign g3 = base_i - GW'(3);

  always_comb begin
    if (start_i[g1])      dist_o = 2'd1;
    else if (start_i[g2]) dist_o = 2'd2;
    else if (start_i[g3]) dist_o = 2'd3;
    else                  dist_o = 2'd0;
    none_o = (dist_o == 2'd0);
  end

endmodule

// File: rtl/regwin_rf.sv
// Physical storage addressed through the window offset.
module regwin_rf #(
  parameter int NAREG = 32,
  parameter int DW    = 32,
  parameter int PW    = 5
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [3:0]    wl_i,
  input  logic [DW-1:0] wd_i,
  input  logic [PW-1:0] off_i,
  input  logic [3:0]    ral_i,
  input  logic [3:0]    rbl_i,
  output logic [DW-1:0] rda_o,
  output logic [DW-1:0] rdb_o
);

  logic [DW-1:0] mem [NAREG];
  logic [PW-1:0] wp, pa, pb;

  assign wp = off_i + PW'(wl_i);
  assign pa = off_i + PW'(ral_i);
  assign pb = off_i + PW'(rbl_i);

  always_ff @(posedge clk) begin
    for (int i = 0; i < NAREG; i++) begin
      if (we_i && (wp == PW'(i))) mem[i] <= wd_i;
    end
  end

  assign rda_o = mem[pa];
  assign rdb_o = mem[pb];

endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
  import regwin_pkg::*;
#(
  parameter int NAREG = 32,
  parameter int DW    = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           ovf_en,
  input  logic                           op_valid,
  input  logic [2:0]                     op_code,
  input  logic [3:0]                     op_s,
  input  logic [11:0]                    op_imm,
  input  logic [1:0]                     op_callinc,
  input  logic [NAREG/4-1:0]             op_arg,
  input  logic [1:0]                     op_pc_region,
  input  logic                           rf_we,
  input  logic [3:0]                     rf_waddr,
  input  logic [DW-1:0]                  rf_wdata,
  input  logic [3:0]                     rf_raddr,
  output logic [DW-1:0]                  rf_rdata,
  output logic [$clog2(NAREG/4)-1:0]     win_base,
  output logic [NAREG/4-1:0]             win_start,
  output logic                           exc_mode,
  output logic [$clog2(NAREG/4)-1:0]     saved_base,
  output logic                           trap_valid,
  output logic [3:0]                     trap_code,
  output logic                           ret_valid,
  output logic [DW-1:0]                  ret_pc,
  output logic                           busy
);

  localparam int NGRP = NAREG / 4;
  localparam int GW   = $clog2(NGRP);
  localparam int PW   = $clog2(NAREG);

  win_op_e op;
  assign op = win_op_e'(op_code);

  // state
  logic [GW-1:0]   base_q, base_d;
  logic [NGRP-1:0] map_q, map_d;
  logic            exc_q, exc_d;
  logic [GW-1:0]   owb_q, owb_d;
  logic            tv_q, tv_d;
  logic [3:0]      tc_q, tc_d;
  logic            rv_q, rv_d;
  logic [DW-1:0]   rpc_q, rpc_d;
  logic            rpc_en;

  // datapath links
  logic            scan_ovf;
  logic [GW-1:0]   scan_adv;
  logic [3:0]      scan_code;
  logic [1:0]      back_dist;
  logic            back_none;
  logic [DW-1:0]   rdb;
  logic [3:0]      rbl;
  logic            ent_we;
  logic            wr_en;
  logic [3:0]      wr_l;
  logic [DW-1:0]   wr_d;
  logic [1:0]      ret_n;
  logic            mode_ok;
  logic [GW-1:0]   nb;

  regwin_scan #(.NGRP(NGRP), .GW(GW)) scan_i (
    .start_i   (map_q),
    .base_i    (base_q),
    .callinc_i (op_callinc),
    .ovf_o     (scan_ovf),
    .adv_o     (scan_adv),
    .code_o    (scan_code)
  );

  regwin_lookback #(.NGRP(NGRP), .GW(GW)) back_i (
    .start_i (map_q),
    .base_i  (base_q),
    .dist_o  (back_dist),
    .none_o  (back_none)
  );

  assign rbl = (op == WOP_RETURN) ? 4'd0 : {2'b00, op_s[1:0]};

  regwin_rf #(.NAREG(NAREG), .DW(DW), .PW(PW)) rf_i (
    .clk   (clk),
    .we_i  (wr_en),
    .wl_i  (wr_l),
    .wd_i  (wr_d),
    .off_i ({base_q, 2'b00}),
    .ral_i (rf_raddr),
    .rbl_i (rbl),
    .rda_o (rf_rdata),
    .rdb_o (rdb)
  );

  // write port arbitration: an operation owns the port in its cycle
  assign wr_en = op_valid ? ent_we : rf_we;
  assign wr_l  = op_valid ? {op_callinc, op_s[1:0]} : rf_waddr;
  assign wr_d  = op_valid ? (rdb - (DW'(op_imm) << 3)) : rf_wdata;

  assign ret_n   = rdb[DW-1 -: 2];
  assign mode_ok = ovf_en && !exc_q;

  // next-state
  always_comb begin
    base_d = base_q;
    map_d  = map_q;
    exc_d  = exc_q;
    owb_d  = owb_q;
    tv_d   = 1'b0;
    tc_d   = TC_NONE;
    rv_d   = 1'b0;
    rpc_d  = rpc_q;
    rpc_en = 1'b0;
    ent_we = 1'b0;
    nb     = base_q;

    if (op_valid) begin
      unique case (op)
        WOP_ENTRY: begin
          if ((op_s > 4'd3) || !mode_ok) begin
            tv_d  = 1'b1;
            tc_d  = TC_ILLEGAL;
            exc_d = 1'b1;
          end else if (scan_ovf) begin
            base_d = base_q + scan_adv;
            owb_d  = base_q;
            exc_d  = 1'b1;
            tv_d   = 1'b1;
            tc_d   = scan_code;
          end else begin
            ent_we    = 1'b1;
            nb        = base_q + GW'(op_callinc);
            base_d    = nb;
            map_d[nb] = 1'b1;
          end
        end

        WOP_RETURN: begin
          if ((ret_n == 2'd0) || (!back_none && (back_dist != ret_n)) || !mode_ok) begin
            tv_d  = 1'b1;
            tc_d  = TC_ILLEGAL;
            exc_d = 1'b1;
          end else begin
            nb     = base_q - GW'(ret_n);
            base_d = nb;
            if (map_q[nb]) begin
              map_d[base_q] = 1'b0;
              rv_d          = 1'b1;
              rpc_en        = 1'b1;
              rpc_d         = {op_pc_region, rdb[DW-3:0]};
            end else begin
              owb_d = base_q;
              exc_d = 1'b1;
              tv_d  = 1'b1;
              tc_d  = TC_UNF4 + {2'b00, ret_n} - 4'd1;
            end
          end
        end

        WOP_ROTATE:  base_d = base_q + GW'($signed(op_arg[3:0]));

        WOP_SPMOVE: begin
          if (back_none) begin
            tv_d  = 1'b1;
            tc_d  = TC_ALLOCA;
            exc_d = 1'b1;
          end
        end

        WOP_RESTORE: base_d = owb_q;
        WOP_SETBASE: base_d = op_arg[GW-1:0];
        WOP_SETMAP:  map_d  = op_arg;
        WOP_CLREXC:  exc_d  = 1'b0;
        default: ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      map_q  <= NGRP'(1);
      exc_q  <= 1'b0;
      owb_q  <= '0;
      tv_q   <= 1'b0;
      tc_q   <= TC_NONE;
      rv_q   <= 1'b0;
      rpc_q  <= '0;
    end else begin
      base_q <= base_d;
      map_q  <= map_d;
      exc_q  <= exc_d;
      owb_q  <= owb_d;
      tv_q   <= tv_d;
      tc_q   <= tc_d;
      rv_q   <= rv_d;
      if (rpc_en) rpc_q <= rpc_d;
    end
  end

  assign win_base   = base_q;
  assign win_start  = map_q;
  assign exc_mode   = exc_q;
  assign saved_base = owb_q;
  assign trap_valid = tv_q;
  assign trap_code  = tc_q;
  assign ret_valid  = rv_q;
  assign ret_pc     = rpc_q;
  assign busy       = 1'b0;

endmodule

// File: rtl/regwin_ctrl_chk.sv
module regwin_ctrl_chk #(
  parameter int NAREG = 32,
  parameter int DW    = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       op_valid,
  input logic [1:0]                 op_pc_region,
  input logic [$clog2(NAREG/4)-1:0] win_base,
  input logic [NAREG/4-1:0]         win_start,
  input logic                       exc_mode,
  input logic [$clog2(NAREG/4)-1:0] saved_base,
  input logic                       trap_valid,
  input logic [3:0]                 trap_code,
  input logic                       ret_valid,
  input logic [DW-1:0]              ret_pc
);

  AST_TRAP_SETS_EXC: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> exc_mode); // R4

  AST_ILLEGAL_KEEPS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && trap_code == 4'd1) |-> (win_base == $past(win_base) && win_start == $past(win_start))); // R3

  AST_SAVED_OLD_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && trap_code >= 4'd3) |-> (saved_base == $past(win_base))); // R8

  AST_RET_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> (ret_pc[DW-1 -: 2] == $past(op_pc_region))); // R7

  AST_RET_NOT_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> !trap_valid); // R12

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(op_valid) |-> ($stable(win_base) && $stable(win_start) && $stable(exc_mode) && !trap_valid)); // R12

endmodule

bind regwin_ctrl regwin_ctrl_chk #(.NAREG(NAREG), .DW(DW)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .op_valid     (op_valid),
  .op_pc_region (op_pc_region),
  .win_base     (win_base),
  .win_start    (win_start),
  .exc_mode     (exc_mode),
  .saved_base   (saved_base),
  .trap_valid   (trap_valid),
  .trap_code    (trap_code),
  .ret_valid    (ret_valid),
  .ret_pc       (ret_pc)
);

// File: tb/regwin_ctrl_tb_top.sv
module regwin_ctrl_tb_top;

  localparam int NAREG = 32;
  localparam int DW    = 32;
  localparam int NG    = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ovf_en = 1'b1;
  logic          op_valid = 1'b0;
  logic [2:0]    op_code = '0;
  logic [3:0]    op_s = '0;
  logic [11:0]   op_imm = '0;
  logic [1:0]    op_callinc = '0;
  logic [NG-1:0] op_arg = '0;
  logic [1:0]    op_pc_region = '0;
  logic          rf_we = 1'b0;
  logic [3:0]    rf_waddr = '0;
  logic [DW-1:0] rf_wdata = '0;
  logic [3:0]    rf_raddr = '0;
  logic [DW-1:0] rf_rdata;
  logic [2:0]    win_base;
  logic [NG-1:0] win_start;
  logic          exc_mode;
  logic [2:0]    saved_base;
  logic          trap_valid;
  logic [3:0]    trap_code;
  logic          ret_valid;
  logic [DW-1:0] ret_pc;
  logic          busy;

  regwin_ctrl #(.NAREG(NAREG), .DW(DW)) dut_i (.*);

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  // bench model
  logic [31:0]   mphys [NAREG];
  int            mbase;
  logic [NG-1:0] mmap;
  bit            mexc;
  int            mowb;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [2:0] code, input logic [3:0] s, input logic [11:0] imm,
                       input logic [1:0] ci, input logic [NG-1:0] arg, input logic [1:0] pcr);
    @(negedge clk);
    op_valid = 1'b1; op_code = code; op_s = s; op_imm = imm;
    op_callinc = ci; op_arg = arg; op_pc_region = pcr;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic rf_write(input int l, input logic [31:0] d);
    @(negedge clk);
    rf_we = 1'b1; rf_waddr = 4'(l); rf_wdata = d;
    @(negedge clk);
    rf_we = 1'b0;
    mphys[(4*mbase + l) % NAREG] = d;
  endtask

  task automatic rf_read(input int l, output logic [31:0] d);
    rf_raddr = 4'(l);
    #1;
    d = rf_rdata;
  endtask

  task automatic set_win(input int b, input logic [NG-1:0] m);
    do_op(3'd5, 4'd0, 12'd0, 2'd0, NG'(b), 2'd0);
    do_op(3'd6, 4'd0, 12'd0, 2'd0, m, 2'd0);
    do_op(3'd7, 4'd0, 12'd0, 2'd0, '0, 2'd0);
    mbase = b; mmap = m; mexc = 0;
  endtask

  task automatic chk_state(input string req);
    chk({req, " base"}, 32'(win_base), 32'(mbase));
    chk({req, " map"}, 32'(win_start), 32'(mmap));
    chk({req, " exc"}, 32'(exc_mode), 32'(mexc));
  endtask

  task automatic chk_window(input string req);
    logic [31:0] d;
    for (int l = 0; l < 16; l++) begin
      rf_read(l, d);
      chk(req, d, mphys[(4*mbase + l) % NAREG]);
    end
  endtask

  // expected entry outcome, from R3, R4, R5
  function automatic int model_entry(input int s, input int imm, input int ci);
    logic [NG-1:0] v;
    int k;
    if (s > 3 || !ovf_en || mexc) begin
      mexc = 1;
      return 1;
    end
    for (int i = 0; i < NG; i++) v[i] = mmap[(mbase + 1 + i) % NG];
    if (ci > 0 && (v & NG'((1 << ci) - 1)) != 0) begin
      k = 0;
      while (!v[k]) k++;
      mowb = mbase;
      mbase = (mbase + k + 1) % NG;
      mexc = 1;
      if (v[k+1]) return 3;
      if (v[k+2]) return 4;
      return 5;
    end
    mphys[(4*mbase + 4*ci + s) % NAREG] = mphys[(4*mbase + s) % NAREG] - 32'(imm * 8);
    mbase = (mbase + ci) % NG;
    mmap[mbase] = 1'b1;
    return 0;
  endfunction

  // expected return outcome, from R6, R7, R8
  function automatic int model_ret(input int n);
    int m, nb;
    m = 0;
    for (int j = 3; j >= 1; j--) if (mmap[(mbase + NG - j) % NG]) m = j;
    if (n == 0 || (m != 0 && m != n) || !ovf_en || mexc) begin
      mexc = 1;
      return 1;
    end
    nb = (mbase + NG - n) % NG;
    if (mmap[nb]) begin
      mmap[mbase] = 1'b0;
      mbase = nb;
      return 0;
    end
    mowb = mbase;
    mbase = nb;
    mexc = 1;
    return 5 + n;
  endfunction

  logic [NG-1:0] pats [6];
  bit done = 0;

  initial begin
    logic [31:0] d;
    int code, s, imm;
    pats[0] = 8'h01; pats[1] = 8'hFF; pats[2] = 8'h80;
    pats[3] = 8'h24; pats[4] = 8'h92; pats[5] = 8'h5A;
    mbase = 0; mmap = 8'h01; mexc = 0; mowb = 0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 base", 32'(win_base), 0);
    chk("R1 map", 32'(win_start), 32'h1);
    chk("R1 exc", 32'(exc_mode), 0);
    chk("R1 trap", 32'(trap_valid), 0);
    chk("R1 ret", 32'(ret_valid), 0);
    chk("R1 busy", 32'(busy), 0);

    // R2 fill the file through every base, then read back every window
    for (int b = 0; b < NG; b++) begin
      set_win(b, 8'h01);
      for (int l = 0; l < 4; l++) rf_write(l, 32'hA500_0000 + 32'(b * 256 + l * 17));
    end
    for (int b = 0; b < NG; b++) begin
      set_win(b, 8'h01);
      chk_window("R2 mapping");
    end

    // R2 port write ignored while an operation is accepted
    set_win(2, 8'h04);
    @(negedge clk);
    op_valid = 1'b1; op_code = 3'd2; op_arg = 8'h00;
    rf_we = 1'b1; rf_waddr = 4'd5; rf_wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    op_valid = 1'b0; rf_we = 1'b0;
    rf_read(5, d);
    chk("R2 write ignored during op", d, mphys[(4*2 + 5) % NAREG]);

    // R4 R5 entry sweep
    for (int b = 0; b < NG; b++) begin
      for (int p = 0; p < 6; p++) begin
        for (int ci = 0; ci < 4; ci++) begin
          s = (b + ci) % 4;
          imm = b * 5 + ci + p;
          set_win(b, pats[p]);
          code = model_entry(s, imm, ci);
          do_op(3'd0, 4'(s), 12'(imm), 2'(ci), '0, 2'd0);
          chk("R4/R5 entry trap_valid", 32'(trap_valid), 32'(code != 0));
          chk("R4 entry trap_code", 32'(trap_code), 32'(code));
          chk_state("R5 entry");
          if (code != 0) chk("R4 saved base", 32'(saved_base), 32'(mowb));
          else chk_window("R5 entry write");
        end
      end
    end

    // R12 pulse lasts one cycle
    set_win(0, 8'h02);
    code = model_entry(0, 0, 1);
    do_op(3'd0, 4'd0, 12'd0, 2'd1, '0, 2'd0);
    chk("R12 pulse present", 32'(trap_valid), 1);
    @(negedge clk);
    chk("R12 pulse gone", 32'(trap_valid), 0);
    chk("R12 state held", 32'(win_base), 32'(mbase));

    // R9 restore after that overflow
    do_op(3'd4, 4'd0, 12'd0, 2'd0, '0, 2'd0);
    mbase = mowb;
    chk("R9 restore base", 32'(win_base), 32'(mbase));

    // R3 illegal entries
    for (int s2 = 4; s2 < 16; s2++) begin
      set_win(s2 % NG, 8'h01);
      code = model_entry(s2, 1, 1);
      do_op(3'd0, 4'(s2), 12'd1, 2'd1, '0, 2'd0);
      chk("R3 big s code", 32'(trap_code), 32'(code));
      chk_state("R3 big s");
    end
    set_win(3, 8'h08);
    ovf_en = 1'b0;
    code = model_entry(1, 2, 2);
    do_op(3'd0, 4'd1, 12'd2, 2'd2, '0, 2'd0);
    chk("R3 ovf off code", 32'(trap_code), 32'(code));
    chk_state("R3 ovf off");
    ovf_en = 1'b1;
    code = model_entry(1, 2, 2);
    do_op(3'd0, 4'd1, 12'd2, 2'd2, '0, 2'd0);
    chk("R3 exc set code", 32'(trap_code), 32'(code));
    chk_state("R3 exc set");
    chk_window("R3 file untouched");

    // R6 R7 R8 return sweep
    for (int b = 0; b < NG; b++) begin
      for (int p = 0; p < 6; p++) begin
        for (int n = 0; n < 4; n++) begin
          logic [31:0] r0;
          set_win(b, pats[p]);
          r0 = {2'(n), 30'(32'h0123_4567 + b * 97 + p * 13)};
          rf_write(0, r0);
          code = model_ret(n);
          do_op(3'd1, 4'd0, 12'd0, 2'd0, '0, 2'(b));
          chk("R6/R8 return trap_code", 32'(trap_code), 32'(code));
          chk("R6 return trap_valid", 32'(trap_valid), 32'(code != 0));
          chk("R7 ret_valid", 32'(ret_valid), 32'(code == 0));
          if (code == 0) chk("R7 ret_pc", ret_pc, {2'(b), r0[29:0]});
          if (code >= 6) chk("R8 saved base", 32'(saved_base), 32'(mowb));
          chk_state("R8 return");
        end
      end
    end

    // R10 stack-pointer move
    for (int b = 0; b < NG; b++) begin
      for (int p = 0; p < 6; p++) begin
        bit none;
        set_win(b, pats[p]);
        none = !(pats[p][(b+7)%NG] || pats[p][(b+6)%NG] || pats[p][(b+5)%NG]);
        do_op(3'd3, 4'd0, 12'd0, 2'd0, '0, 2'd0);
        if (none) mexc = 1;
        chk("R10 alloca code", 32'(trap_code), none ? 2 : 0);
        chk_state("R10 spmove");
      end
    end

    // R11 rotate by every signed amount from every base
    for (int b = 0; b < NG; b++) begin
      for (int dl = -8; dl < 8; dl++) begin
        set_win(b, 8'h11);
        do_op(3'd2, 4'd0, 12'd0, 2'd0, NG'(4'(dl)), 2'd0);
        mbase = (b + dl + 16) % NG;
        chk("R11 rotate", 32'(win_base), 32'(mbase));
      end
    end
    set_win(6, 8'hC3);
    chk_state("R11 set base/map/clear");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule